// File: doc/BRIEF.md
# Oversampled Serial Character Receiver

This block recovers characters from an asynchronous serial line. A 16x oversampling enable paces a bit timer. A start edge is confirmed at the centre of the start bit, and every later bit is taken at its own centre. Once the last stop bit has been sampled, the completed character is moved from the shift register into a one-entry holding buffer. That move sets the buffer-full flag and raises the receive interrupt. The flag stays set until the consumer pulses a read strobe.

The frame format matches a companion transmitter. It has 7, 8 or 9 character bits, optional odd or even parity, and one or two stop bits. The first bit on the wire can be mapped to the least or to the most significant bit. One option inverts only the character bits. A separate option inverts the pin itself, which affects every level including idle. Overrun, framing and parity errors are recorded when the character is moved into the buffer, and an error-sum output combines them. A request-to-send output goes low while the receiver can accept a character.

The controller is a six-state machine. From ST_IDLE, a low line on a tick enters ST_START. At the half-bit point, ST_START returns to ST_IDLE if the line is high again (a glitch) and otherwise moves to ST_DATA. ST_DATA leaves after the last character bit: it goes to ST_PARITY when parity is enabled, and to ST_STOP1 otherwise. ST_PARITY moves on to ST_STOP1. ST_STOP1 moves to ST_STOP2 when two stop bits are configured, and otherwise returns to ST_IDLE with a buffer load. ST_STOP2 returns to ST_IDLE with a buffer load. Dropping the enable forces ST_IDLE from any state.

Top module: `serial_rx_unit`

## Requirements
- R1: A frame is started only while `rx_enable` is 1 and the line (pin XOR `cfg_pin_inv`) is low on a tick. If the line is high again 8 ticks later, the start is discarded with no load and no interrupt.
- R2: A buffer load happens at the centre of the last stop bit. In the following cycle `rx_data` holds the character, `rx_full` is 1 and `rx_irq` is high for exactly one cycle.
- R3: `err_overrun`, `err_frame` and `err_parity` change only on a buffer load. A load with no error clears them.
- R4: `err_frame` is set when any configured stop bit is sampled low on the line.
- R5: When `cfg_par_en` is 1, `err_parity` is set if the count of ones over the line-level character bits plus the parity bit is odd while `cfg_par_odd` is 0, or even while `cfg_par_odd` is 1.
- R6: If `rx_full` is 1 when the bit just before the last stop bit is sampled, the next load sets `err_overrun`, raises no `rx_irq` and leaves `rx_full` at 1.
- R7: A `rd_strobe` cycle with no load clears `rx_full`. A load in the same cycle takes priority.
- R8: `err_sum` is 1 exactly when at least one of the three error flags is 1.
- R9: `cfg_len` codes 00, 01 and 10 (and 11) select 7, 8 and 9 character bits. With `cfg_msb_first` 0, the first bit on the wire becomes bit 0; with 1, it becomes the top character bit. Unused upper bits of `rx_data` read 0.
- R10: `cfg_data_inv` inverts only the character bits. `cfg_pin_inv` inverts every level of the pin, so the idle pin level becomes 0.
- R11: While `rx_enable` is 0, a frame in progress is abandoned and the error flags are 0 from the next cycle. `rx_data` and `rx_full` are kept.
- R12: `rts_n` is 0 exactly when `rx_enable` is 1 and `rx_full` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | 16x oversampling enable |
| rx_pin | input | 1 | Serial input pin |
| rx_enable | input | 1 | Receiver enable |
| cfg_len | input | 2 | Character length code |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 odd parity, 0 even |
| cfg_two_stop | input | 1 | Two stop bits |
| cfg_msb_first | input | 1 | First wire bit is the top character bit |
| cfg_data_inv | input | 1 | Invert character bits only |
| cfg_pin_inv | input | 1 | Invert all pin levels |
| rd_strobe | input | 1 | Buffer read pulse |
| rx_data | output | 9 | Receive buffer |
| rx_full | output | 1 | Buffer holds an unread character |
| rx_irq | output | 1 | One-cycle receive interrupt |
| err_overrun | output | 1 | Overrun flag |
| err_frame | output | 1 | Framing error flag |
| err_parity | output | 1 | Parity error flag |
| err_sum | output | 1 | OR of the error flags |
| rts_n | output | 1 | Ready to receive, active low |

## Verification
The hardest case to reach is an overrun. It needs a full buffer at the one sample point just before the last stop bit of the next frame, and it must be shown that the interrupt is withheld while the flag appears only at the load. The bench gets there by sending two frames back to back without pulsing the read strobe. It then counts interrupt pulses and looks at the flags after the second frame. A second awkward case is showing that an error flag holds while the next frame is still arriving. For this, a good frame is sent in a parallel thread and the stale parity flag is sampled halfway through that frame.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

    localparam int CHAR_MAX = 9;
    localparam int IDX_W    = $clog2(CHAR_MAX + 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP1,
        ST_STOP2
    } rx_state_t;

    function automatic logic [IDX_W-1:0] char_bits(input logic [1:0] code);
        unique case (code)
            2'b00:   return IDX_W'(7);
            2'b01:   return IDX_W'(8);
            default: return IDX_W'(9);
        endcase
    endfunction

endpackage

// File: rtl/rx_bit_timer.sv
module rx_bit_timer #(
    parameter int OVS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic restart,
    output logic mid_hit,
    output logic end_hit
);
    localparam int CW   = $clog2(OVS);
    localparam int HALF = OVS / 2;

    logic [CW-1:0] cnt;

    assign mid_hit = tick && (cnt == CW'(HALF - 1));
    assign end_hit = tick && (cnt == CW'(OVS - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (restart)
            cnt <= '0;
        else if (tick)
            cnt <= (cnt == CW'(OVS - 1)) ? '0 : cnt + 1'b1;
    end
endmodule

// File: rtl/rx_char_decode.sv
module rx_char_decode #(
    parameter int W  = 9,
    parameter int IW = 4
) (
    input  logic [W-1:0]  raw,
    input  logic [IW-1:0] nbits,
    input  logic          msb_first,
    input  logic          data_inv,
    input  logic          par_bit,
    input  logic          par_odd,
    output logic [W-1:0]  char_out,
    output logic          par_bad
);
    logic ones;

    always_comb begin
        char_out = '0;
        ones     = par_bit;
        for (int i = 0; i < W; i++) begin
            if (i < int'(nbits)) begin
                ones = ones ^ raw[i];
                if (msb_first)
                    char_out[i] = raw[int'(nbits) - 1 - i] ^ data_inv;
                else
                    char_out[i] = raw[i] ^ data_inv;
            end
        end
        par_bad = ones ^ par_odd;
    end
endmodule

// File: rtl/serial_rx_unit.sv
module serial_rx_unit
    import serial_rx_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic                rx_pin,
    input  logic                rx_enable,
    input  logic [1:0]          cfg_len,
    input  logic                cfg_par_en,
    input  logic                cfg_par_odd,
    input  logic                cfg_two_stop,
    input  logic                cfg_msb_first,
    input  logic                cfg_data_inv,
    input  logic                cfg_pin_inv,
    input  logic                rd_strobe,
    output logic [CHAR_MAX-1:0] rx_data,
    output logic                rx_full,
    output logic                rx_irq,
    output logic                err_overrun,
    output logic                err_frame,
    output logic                err_parity,
    output logic                err_sum,
    output logic                rts_n
);
    rx_state_t state, nxt;

    logic                line;
    logic                restart, mid_hit, end_hit;
    logic [CHAR_MAX-1:0] raw;
    logic [IDX_W-1:0]    idx, nbits;
    logic                last_data;
    logic                par_bit, stop_bad, ovr_pend;
    logic                busy, buf_load, pre_last, frame_bad;
    logic [CHAR_MAX-1:0] char_w;
    logic                par_bad;

    assign line      = rx_pin ^ cfg_pin_inv;
    assign nbits     = char_bits(cfg_len);
    assign last_data = (idx == nbits - 1'b1);
    assign busy      = (state != ST_IDLE);
    assign restart   = (state == ST_IDLE) || (state == ST_START && mid_hit);

    rx_bit_timer #(.OVS(OVS)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .restart (restart),
        .mid_hit (mid_hit),
        .end_hit (end_hit)
    );

    rx_char_decode #(.W(CHAR_MAX), .IW(IDX_W)) u_decode (
        .raw       (raw),
        .nbits     (nbits),
        .msb_first (cfg_msb_first),
        .data_inv  (cfg_data_inv),
        .par_bit   (par_bit),
        .par_odd   (cfg_par_odd),
        .char_out  (char_w),
        .par_bad   (par_bad)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= nxt;
    end

    // transitions
    always_comb begin
        nxt = state;
        if (!rx_enable) begin
            nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:   if (tick && !line) nxt = ST_START;
                ST_START:  if (mid_hit) nxt = line ? ST_IDLE : ST_DATA;
                ST_DATA:   if (end_hit && last_data)
                               nxt = cfg_par_en ? ST_PARITY : ST_STOP1;
                ST_PARITY: if (end_hit) nxt = ST_STOP1;
                ST_STOP1:  if (end_hit) nxt = cfg_two_stop ? ST_STOP2 : ST_IDLE;
                ST_STOP2:  if (end_hit) nxt = ST_IDLE;
                default:   nxt = ST_IDLE;
            endcase
        end
    end

    assign buf_load = rx_enable && end_hit &&
                      ((state == ST_STOP1 && !cfg_two_stop) || state == ST_STOP2);

    assign pre_last = rx_enable && end_hit &&
                      ((state == ST_STOP1 && cfg_two_stop) ||
                       (!cfg_two_stop && (state == ST_PARITY ||
                        (state == ST_DATA && last_data && !cfg_par_en))));

    assign frame_bad = ((state == ST_STOP2) ? stop_bad : 1'b0) | !line;

    // shift path
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            raw      <= '0;
            idx      <= '0;
            par_bit  <= 1'b0;
            stop_bad <= 1'b0;
            ovr_pend <= 1'b0;
        end else begin
            if (state == ST_START && mid_hit) begin
                idx      <= '0;
                stop_bad <= 1'b0;
                ovr_pend <= 1'b0;
            end
            if (state == ST_DATA && end_hit) begin
                raw[idx] <= line;
                idx      <= idx + 1'b1;
            end
            if (state == ST_PARITY && end_hit)
                par_bit <= line;
            if (state == ST_STOP1 && end_hit)
                stop_bad <= !line;
            if (pre_last)
                ovr_pend <= rx_full;
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_data     <= '0;
            rx_full     <= 1'b0;
            rx_irq      <= 1'b0;
            err_overrun <= 1'b0;
            err_frame   <= 1'b0;
            err_parity  <= 1'b0;
        end else begin
            rx_irq <= 1'b0;
            if (buf_load) begin
                rx_data     <= char_w;
                rx_full     <= 1'b1;
                rx_irq      <= !ovr_pend;
                err_overrun <= ovr_pend;
                err_frame   <= frame_bad;
                err_parity  <= cfg_par_en && par_bad;
            end else if (rd_strobe) begin
                rx_full <= 1'b0;
            end
            if (!rx_enable) begin
                err_overrun <= 1'b0;
                err_frame   <= 1'b0;
                err_parity  <= 1'b0;
            end
        end
    end

    assign err_sum = err_overrun | err_frame | err_parity;
    assign rts_n   = !(rx_enable && !rx_full);

endmodule

// File: rtl/serial_rx_checker.sv
module serial_rx_checker (
    input logic clk,
    input logic rst_n,
    input logic rx_enable,
    input logic rd_strobe,
    input logic rx_full,
    input logic rx_irq,
    input logic err_overrun,
    input logic err_frame,
    input logic err_parity,
    input logic err_sum,
    input logic busy,
    input logic buf_load,
    input logic ovr_pend
);
    AST_START_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(rx_enable)); // R1

    AST_IRQ_WITH_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |-> rx_full); // R2

    AST_FLAGS_AT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(err_frame) || $rose(err_parity) || $rose(err_overrun)) |-> $past(buf_load)); // R3

    AST_OVR_MUTES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_load && ovr_pend) |=> (!rx_irq && err_overrun && rx_full)); // R6

    AST_READ_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && !buf_load) |=> !rx_full); // R7

    AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_enable |=> !err_sum); // R11
endmodule

bind serial_rx_unit serial_rx_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_enable   (rx_enable),
    .rd_strobe   (rd_strobe),
    .rx_full     (rx_full),
    .rx_irq      (rx_irq),
    .err_overrun (err_overrun),
    .err_frame   (err_frame),
    .err_parity  (err_parity),
    .err_sum     (err_sum),
    .busy        (busy),
    .buf_load    (buf_load),
    .ovr_pend    (ovr_pend)
);

// File: tb/serial_rx_unit_test.sv
module serial_rx_unit_test;

    logic       clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
    logic       rx_pin = 1'b1, rx_enable = 1'b0, rd_strobe = 1'b0;
    logic [1:0] cfg_len = 2'b01;
    logic       cfg_par_en = 1'b0, cfg_par_odd = 1'b0, cfg_two_stop = 1'b0;
    logic       cfg_msb_first = 1'b0, cfg_data_inv = 1'b0, cfg_pin_inv = 1'b0;
    logic [8:0] rx_data;
    logic       rx_full, rx_irq, err_overrun, err_frame, err_parity, err_sum, rts_n;

    int checks = 0, errors = 0, irq_cnt = 0;

    serial_rx_unit uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .rx_pin(rx_pin), .rx_enable(rx_enable),
        .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .cfg_two_stop(cfg_two_stop), .cfg_msb_first(cfg_msb_first),
        .cfg_data_inv(cfg_data_inv), .cfg_pin_inv(cfg_pin_inv), .rd_strobe(rd_strobe),
        .rx_data(rx_data), .rx_full(rx_full), .rx_irq(rx_irq), .err_overrun(err_overrun),
        .err_frame(err_frame), .err_parity(err_parity), .err_sum(err_sum), .rts_n(rts_n)
    );

    always #4 clk = ~clk;
    always @(negedge clk) tick <= ~tick;
    always @(posedge clk) if (rx_irq) irq_cnt <= irq_cnt + 1;

    // {len[18:17], par_en, par_odd, two_stop, msb_first, data_inv, pin_inv, char[10:2], bad_par, bad_stop}
    localparam logic [18:0] VEC [8] = '{
        {2'b01, 6'b000000, 9'h0A5, 2'b00},
        {2'b00, 6'b100000, 9'h05A, 2'b00},
        {2'b10, 6'b111100, 9'h1C3, 2'b00},
        {2'b01, 6'b000010, 9'h03C, 2'b00},
        {2'b01, 6'b100101, 9'h081, 2'b00},
        {2'b00, 6'b110000, 9'h011, 2'b10},
        {2'b01, 6'b000000, 9'h07E, 2'b01},
        {2'b10, 6'b001011, 9'h155, 2'b01}
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic hold_bit(input logic lvl);
        rx_pin = lvl ^ cfg_pin_inv;
        repeat (32) @(negedge clk);
    endtask

    task automatic send_frame(input logic [8:0] c, input logic badp, input logic bads);
        int n;
        logic [8:0] msk, dl;
        logic p;
        n   = (cfg_len == 2'b00) ? 7 : (cfg_len == 2'b01) ? 8 : 9;
        msk = 9'((1 << n) - 1);
        dl  = c & msk;
        if (cfg_data_inv) dl = dl ^ msk;
        hold_bit(1'b0);
        for (int k = 0; k < n; k++)
            hold_bit(cfg_msb_first ? dl[n-1-k] : dl[k]);
        p = (^dl) ^ cfg_par_odd;
        if (badp) p = ~p;
        if (cfg_par_en) hold_bit(p);
        if (cfg_two_stop) hold_bit(1'b1);
        hold_bit(!bads);
        hold_bit(1'b1);
    endtask

    task automatic do_read();
        rd_strobe = 1'b1;
        @(negedge clk);
        rd_strobe = 1'b0;
        @(negedge clk);
    endtask

    task automatic set_cfg(input logic [1:0] l, input logic pe, input logic po, input logic ts,
                           input logic mf, input logic di, input logic pi);
        cfg_len = l; cfg_par_en = pe; cfg_par_odd = po; cfg_two_stop = ts;
        cfg_msb_first = mf; cfg_data_inv = di; cfg_pin_inv = pi;
        rx_pin = ~pi;
        repeat (40) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int i0;
        logic [8:0] msk;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R2 reset full", rx_full, 0);
        chk("R8 reset err_sum", err_sum, 0);
        chk("R12 rts disabled", rts_n, 1);

        // R1: frame while disabled is ignored
        i0 = irq_cnt;
        send_frame(9'h033, 1'b0, 1'b0);
        chk("R1 disabled no load", rx_full, 0);
        chk("R1 disabled no irq", irq_cnt - i0, 0);

        rx_enable = 1'b1;
        @(negedge clk);
        chk("R12 rts enabled empty", rts_n, 0);

        // table walk
        foreach (VEC[v]) begin
            set_cfg(VEC[v][18:17], VEC[v][16], VEC[v][15], VEC[v][14],
                    VEC[v][13], VEC[v][12], VEC[v][11]);
            msk = (cfg_len == 2'b00) ? 9'h07F : (cfg_len == 2'b01) ? 9'h0FF : 9'h1FF;
            i0 = irq_cnt;
            send_frame(VEC[v][10:2], VEC[v][1], VEC[v][0]);
            chk("R9 R10 data", rx_data, VEC[v][10:2] & msk);
            chk("R2 full", rx_full, 1);
            chk("R2 irq pulse", irq_cnt - i0, 1);
            chk("R5 parity flag", err_parity, VEC[v][1] & VEC[v][16]);
            chk("R4 frame flag", err_frame, VEC[v][0]);
            chk("R8 sum", err_sum, (VEC[v][1] & VEC[v][16]) | VEC[v][0]);
            chk("R12 rts full", rts_n, 1);
            do_read();
            chk("R7 read clears", rx_full, 0);
        end

        // R1: glitch rejected
        set_cfg(2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        i0 = irq_cnt;
        rx_pin = 1'b0;
        repeat (8) @(negedge clk);
        rx_pin = 1'b1;
        repeat (64) @(negedge clk);
        chk("R1 glitch no load", rx_full, 0);
        chk("R1 glitch no irq", irq_cnt - i0, 0);
        send_frame(9'h05C, 1'b0, 1'b0);
        chk("R1 after glitch data", rx_data, 9'h05C);
        do_read();

        // R6: overrun
        i0 = irq_cnt;
        send_frame(9'h011, 1'b0, 1'b0);
        send_frame(9'h022, 1'b0, 1'b0);
        chk("R6 overrun flag", err_overrun, 1);
        chk("R6 irq suppressed", irq_cnt - i0, 1);
        chk("R6 full kept", rx_full, 1);
        chk("R8 sum overrun", err_sum, 1);

        // R11: disable clears flags, keeps buffer
        rx_enable = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R11 flags cleared", err_sum, 0);
        chk("R11 full kept", rx_full, 1);
        do_read();
        chk("R7 read after disable", rx_full, 0);
        rx_enable = 1'b1;

        // R3: flag holds mid-frame, clean load clears it
        set_cfg(2'b01, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        send_frame(9'h0F0, 1'b1, 1'b0);
        chk("R5 parity set", err_parity, 1);
        do_read();
        fork
            send_frame(9'h0F1, 1'b0, 1'b0);
            begin
                repeat (150) @(negedge clk);
                chk("R3 flag held mid-frame", err_parity, 1);
            end
        join
        chk("R3 clean load clears", err_parity, 0);
        chk("R3 data", rx_data, 9'h0F1);

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule